// File: doc/BRIEF.md
# Staggered Half-Width Pipelined ALU

This block is a 32-bit integer unit for addition, subtraction and bitwise logic. It splits each operation across three cycles of a fast clock. The first stage produces the lower 16 result bits and records that half's carry. The second stage uses that carry to produce the upper 16 bits and the overflow indication. The third stage derives the zero and sign flags from both stored halves and presents the finished word.

Each half is forwarded back to the unit's own operand inputs as soon as it exists. An operation that depends on the one issued just before it can therefore issue in the very next cycle. Its lower stage takes the producer's lower half from the first-stage register. One cycle later, its upper stage takes the producer's upper half from the second-stage register. A per-operand select bit on the issue port chooses forwarding instead of the port value.

The unit takes a new operation on any cycle and tolerates idle cycles anywhere in the stream. Results leave in issue order, one per issued operation.

Top module: `sha_alu`

## Requirements
- R1: While rst_n is low, and until an issued operation has travelled through the pipeline, res_valid is low.
- R2: An operation sampled with iss_valid high at rising edge n shows res_valid high after edge n+2. Results come out in issue order, exactly one per issued operation. A cycle with iss_valid low produces no result.
- R3: Opcode 0 (add): res_data is a+b modulo 2^32. res_carry is the carry out of bit 31. res_ovf is set when both operands have the same sign and the result's sign differs from it.
- R4: Opcode 1 (subtract): res_data is a-b modulo 2^32, computed as a + ~b + 1. res_carry is the carry out of that sum, which is 1 exactly when a >= b unsigned. res_ovf is set when the operand signs differ and the result's sign differs from a's sign.
- R5: Opcodes 2, 3 and 4 give bitwise AND, OR and XOR. Opcodes 5 to 7 give a zero result. For all of opcodes 2 to 7, res_carry and res_ovf are 0.
- R6: With res_valid high, res_zero is 1 exactly when all 32 bits of res_data are 0, and res_sign equals res_data bit 31.
- R7: The carry out of the lower 16 bits enters the upper 16-bit sum, so a carry or borrow crosses bit 15 correctly.
- R8: With iss_a_sel (or iss_b_sel) high, operand A (or B) is the result of the operation issued in the immediately preceding cycle, and the value on iss_a (or iss_b) has no effect. This holds for chains of dependent operations issued on consecutive cycles. With the select low, the port value is used.
- R9: While res_valid is low, res_data and all four flags keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; every stage register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk; clears the stage valid bits |
| iss_valid | input | 1 | An operation is offered this cycle |
| iss_op | input | 3 | Opcode: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5-7 zero result |
| iss_a | input | 32 | Operand A from the issue side |
| iss_b | input | 32 | Operand B from the issue side |
| iss_a_sel | input | 1 | Take operand A from the preceding operation's result |
| iss_b_sel | input | 1 | Take operand B from the preceding operation's result |
| res_valid | output | 1 | res_data and the flags hold a new result |
| res_data | output | 32 | Result word |
| res_zero | output | 1 | Result is all zeros |
| res_sign | output | 1 | Result bit 31 |
| res_carry | output | 1 | Carry out of the arithmetic sum |
| res_ovf | output | 1 | Signed overflow |

## Verification
Every issued operation is due three rising edges after it was sampled: the first-stage, second-stage and output registers each add one. The driver therefore records each expected result together with the cycle count at the moment it drives the issue. The monitor samples at the falling edge and requires that each result pops exactly three counts later, so an early, late, missing or extra result is caught as well as a wrong value. For forwarded operands, the bench computes the expected value from its own record of the previous issue's result and puts a junk value on the ignored port. While res_valid is low, the monitor compares the outputs against the last result it saw.

// File: rtl/sha_pkg.sv
package sha_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB = 3'd1;
  localparam logic [OP_W-1:0] OP_AND = 3'd2;
  localparam logic [OP_W-1:0] OP_OR  = 3'd3;
  localparam logic [OP_W-1:0] OP_XOR = 3'd4;
endpackage

// File: rtl/sha_slice.sv
// One half-width slice of the datapath: add/sub with carry-in, or bitwise logic.
module sha_slice
  import sha_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            cin_i,
  output logic [W-1:0]    res_o,
  output logic            cout_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  always_comb begin
    b_eff  = (op_i == OP_SUB) ? ~b_i : b_i;
    sum    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    res_o  = '0;
    cout_o = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        res_o  = sum[W-1:0];
        cout_o = sum[W];
      end
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/sha_ovf.sv
// Signed overflow from the sign bits of the upper slice.
module sha_ovf
  import sha_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            a_msb_i,
  input  logic            b_msb_i,
  input  logic            r_msb_i,
  output logic            ovf_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  ovf_o = (a_msb_i == b_msb_i) && (r_msb_i != a_msb_i);
      OP_SUB:  ovf_o = (a_msb_i != b_msb_i) && (r_msb_i != a_msb_i);
      default: ovf_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sha_alu.sv
// Three-stage staggered ALU: lower half, upper half, flags.
module sha_alu
  import sha_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_a,
  input  logic [DATA_W-1:0] iss_b,
  input  logic              iss_a_sel,
  input  logic              iss_b_sel,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_zero,
  output logic              res_sign,
  output logic              res_carry,
  output logic              res_ovf
);
  localparam int HALF_W   = DATA_W / 2;
  localparam int NUM_OPND = 2;

  // stage valid bits
  logic l_vld_q, h_vld_q, f_vld_q;

  // lower-half stage registers
  logic [OP_W-1:0]   l_op_q;
  logic [HALF_W-1:0] l_lo_q;
  logic              l_cy_q;

  // upper-half stage registers
  logic [HALF_W-1:0] h_lo_q;
  logic [HALF_W-1:0] h_hi_q;
  logic              h_cy_q;
  logic              h_ov_q;

  // output stage registers
  logic [DATA_W-1:0] f_data_q;
  logic              f_zero_q, f_sign_q, f_cy_q, f_ov_q;

  // operand paths
  logic [NUM_OPND-1:0][DATA_W-1:0] port_opnd;
  logic [NUM_OPND-1:0]             port_sel;
  logic [NUM_OPND-1:0][HALF_W-1:0] lo_opnd;
  logic [NUM_OPND-1:0][HALF_W-1:0] hi_opnd;

  // combinational stage results
  logic [HALF_W-1:0] lo_res, hi_res;
  logic              lo_cout, hi_cout, hi_ovf, lo_cin;

  // next-state and enables
  logic              l_en, h_en, f_en;
  logic              f_zero_d, f_sign_d;

  assign port_opnd = {iss_b, iss_a};
  assign port_sel  = {iss_b_sel, iss_a_sel};

  // Per-operand forwarding: lower half from the first-stage register at issue,
  // upper half from the second-stage register one cycle later.
  for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
    logic [HALF_W-1:0] hi_port_q;
    logic              sel_q;

    assign lo_opnd[k] = port_sel[k] ? l_lo_q : port_opnd[k][HALF_W-1:0];
    assign hi_opnd[k] = sel_q ? h_hi_q : hi_port_q;

    always_ff @(posedge clk) begin
      if (l_en) begin
        hi_port_q <= port_opnd[k][DATA_W-1:HALF_W];
        sel_q     <= port_sel[k];
      end
    end
  end

  assign lo_cin = (iss_op == OP_SUB);

  sha_slice #(.W(HALF_W)) u_lo_slice (
    .op_i   (iss_op),
    .a_i    (lo_opnd[0]),
    .b_i    (lo_opnd[1]),
    .cin_i  (lo_cin),
    .res_o  (lo_res),
    .cout_o (lo_cout)
  );

  sha_slice #(.W(HALF_W)) u_hi_slice (
    .op_i   (l_op_q),
    .a_i    (hi_opnd[0]),
    .b_i    (hi_opnd[1]),
    .cin_i  (l_cy_q),
    .res_o  (hi_res),
    .cout_o (hi_cout)
  );

  sha_ovf u_ovf (
    .op_i    (l_op_q),
    .a_msb_i (hi_opnd[0][HALF_W-1]),
    .b_msb_i (hi_opnd[1][HALF_W-1]),
    .r_msb_i (hi_res[HALF_W-1]),
    .ovf_o   (hi_ovf)
  );

  // next-state logic
  always_comb begin
    l_en     = iss_valid;
    h_en     = l_vld_q;
    f_en     = h_vld_q;
    f_zero_d = (h_lo_q == '0) && (h_hi_q == '0);
    f_sign_d = h_hi_q[HALF_W-1];
  end

  // valid pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_vld_q <= 1'b0;
      h_vld_q <= 1'b0;
      f_vld_q <= 1'b0;
    end else begin
      l_vld_q <= iss_valid;
      h_vld_q <= l_vld_q;
      f_vld_q <= h_vld_q;
    end
  end

  // data pipeline, clock-enabled per stage
  always_ff @(posedge clk) begin
    if (l_en) begin
      l_op_q <= iss_op;
      l_lo_q <= lo_res;
      l_cy_q <= lo_cout;
    end
    if (h_en) begin
      h_lo_q <= l_lo_q;
      h_hi_q <= hi_res;
      h_cy_q <= hi_cout;
      h_ov_q <= hi_ovf;
    end
    if (f_en) begin
      f_data_q <= {h_hi_q, h_lo_q};
      f_zero_q <= f_zero_d;
      f_sign_q <= f_sign_d;
      f_cy_q   <= h_cy_q;
      f_ov_q   <= h_ov_q;
    end
  end

  assign res_valid = f_vld_q;
  assign res_data  = f_data_q;
  assign res_zero  = f_zero_q;
  assign res_sign  = f_sign_q;
  assign res_carry = f_cy_q;
  assign res_ovf   = f_ov_q;
endmodule

// File: rtl/sha_alu_chk.sv
module sha_alu_chk
  import sha_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic [OP_W-1:0]   iss_op,
  input logic [DATA_W-1:0] iss_a,
  input logic [DATA_W-1:0] iss_b,
  input logic              iss_a_sel,
  input logic              iss_b_sel,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              res_zero,
  input logic              res_sign,
  input logic              res_carry,
  input logic              res_ovf
);
  logic [1:0] since_rst;
  logic       seen_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
      seen_res  <= 1'b0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      if (res_valid) seen_res <= 1'b1;
    end
  end

  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd3) |-> !res_valid);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (res_valid == $past(iss_valid, 3)));

  a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && res_valid && $past(iss_op, 3) == OP_ADD
     && !$past(iss_a_sel, 3) && !$past(iss_b_sel, 3))
    |-> (res_data == $past(iss_a, 3) + $past(iss_b, 3)));

  a_r5_logic_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && res_valid && $past(iss_op, 3) >= OP_AND)
    |-> (!res_carry && !res_ovf));

  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_zero == (res_data == '0)));

  a_r6_sign: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_sign == res_data[DATA_W-1]));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_res && !res_valid) |-> ($stable(res_data) && $stable(res_zero)
      && $stable(res_sign) && $stable(res_carry) && $stable(res_ovf)));
endmodule

bind sha_alu sha_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_op    (iss_op),
  .iss_a     (iss_a),
  .iss_b     (iss_b),
  .iss_a_sel (iss_a_sel),
  .iss_b_sel (iss_b_sel),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_zero  (res_zero),
  .res_sign  (res_sign),
  .res_carry (res_carry),
  .res_ovf   (res_ovf)
);

// File: tb/tb_sha_alu.sv
module tb_sha_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid;
  logic [2:0]  iss_op;
  logic [31:0] iss_a, iss_b;
  logic        iss_a_sel, iss_b_sel;
  logic        res_valid;
  logic [31:0] res_data;
  logic        res_zero, res_sign, res_carry, res_ovf;

  always #5 clk = ~clk;

  sha_alu dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .iss_a_sel(iss_a_sel), .iss_b_sel(iss_b_sel),
    .res_valid(res_valid), .res_data(res_data), .res_zero(res_zero),
    .res_sign(res_sign), .res_carry(res_carry), .res_ovf(res_ovf)
  );

  typedef struct {
    logic [31:0] d;
    logic        z, s, c, v;
    int          due;
    string       req;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic [31:0] last_res = '0;
  logic [31:0] held_d;
  logic [3:0]  held_f;
  bit          have_held = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] op, input logic [31:0] a,
                                 input logic [31:0] b);
    exp_t        e;
    logic [32:0] s;
    e.c = 1'b0;
    e.v = 1'b0;
    case (op)
      3'd0: begin
        s = {1'b0, a} + {1'b0, b};
        e.d = s[31:0]; e.c = s[32];
        e.v = (a[31] == b[31]) && (e.d[31] != a[31]);
      end
      3'd1: begin
        s = {1'b0, a} + {1'b0, ~b} + 33'd1;
        e.d = s[31:0]; e.c = s[32];
        e.v = (a[31] != b[31]) && (e.d[31] != a[31]);
      end
      3'd2: e.d = a & b;
      3'd3: e.d = a | b;
      3'd4: e.d = a ^ b;
      default: e.d = '0;
    endcase
    e.z = (e.d == 32'd0);
    e.s = e.d[31];
    return e;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input bit sa, input bit sb,
                       input string req);
    exp_t e;
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_a = a; iss_b = b;
    iss_a_sel = sa; iss_b_sel = sb;
    e = model(op, sa ? last_res : a, sb ? last_res : b);
    e.due = cyc + 3;
    e.req = req;
    last_res = e.d;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      iss_valid = 1'b0; iss_a_sel = 1'b0; iss_b_sel = 1'b0;
      iss_a = 32'hA5A5_5A5A; iss_b = 32'h5A5A_A5A5; iss_op = 3'd0;
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected result", res_data, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.due, "R2", "result cycle", cyc, e.due);
          check(res_data == e.d, e.req, "data", res_data, e.d);
          check(res_carry == e.c, e.req, "carry", {31'd0, res_carry}, {31'd0, e.c});
          check(res_ovf == e.v, e.req, "overflow", {31'd0, res_ovf}, {31'd0, e.v});
          check(res_zero == e.z, "R6", "zero flag", {31'd0, res_zero}, {31'd0, e.z});
          check(res_sign == e.s, "R6", "sign flag", {31'd0, res_sign}, {31'd0, e.s});
        end
        held_d = res_data;
        held_f = {res_zero, res_sign, res_carry, res_ovf};
        have_held = 1;
      end else if (have_held) begin
        check(res_data == held_d, "R9", "held data", res_data, held_d);
        check({res_zero, res_sign, res_carry, res_ovf} == held_f, "R9", "held flags",
              {28'd0, res_zero, res_sign, res_carry, res_ovf}, {28'd0, held_f});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    iss_valid = 1'b0; iss_op = '0; iss_a = '0; iss_b = '0;
    iss_a_sel = 1'b0; iss_b_sel = 1'b0;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1", "valid in reset", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    check(res_valid == 1'b0, "R1", "valid after reset", {31'd0, res_valid}, 32'd0);

    // add, back to back (R3, R7, R6)
    issue(3'd0, 32'd5, 32'd7, 0, 0, "R3");
    issue(3'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, "R3");
    issue(3'd0, 32'h7FFF_FFFF, 32'd1, 0, 0, "R3");
    issue(3'd0, 32'h0000_FFFF, 32'd1, 0, 0, "R7");
    idle(2);
    // subtract (R4, R7)
    issue(3'd1, 32'd10, 32'd3, 0, 0, "R4");
    issue(3'd1, 32'd3, 32'd10, 0, 0, "R4");
    idle(1);
    issue(3'd1, 32'h8000_0000, 32'd1, 0, 0, "R4");
    issue(3'd1, 32'h1234_5678, 32'h1234_5678, 0, 0, "R4");
    issue(3'd1, 32'h0001_0000, 32'd1, 0, 0, "R7");
    // logic and spare codes (R5)
    issue(3'd2, 32'hF0F0_1234, 32'hFF00_00FF, 0, 0, "R5");
    issue(3'd3, 32'h0F00_0001, 32'h8000_1000, 0, 0, "R5");
    idle(3);
    issue(3'd4, 32'hFFFF_0000, 32'hFF00_FF00, 0, 0, "R5");
    issue(3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R5");
    issue(3'd7, 32'h1234_5678, 32'h1, 0, 0, "R5");
    idle(4);
    // dependent chain with forwarding; ignored port values are junk (R8)
    issue(3'd0, 32'h0000_FFFF, 32'd1, 0, 0, "R8");
    issue(3'd0, 32'hDEAD_BEEF, 32'h0000_FFFF, 1, 0, "R8");
    issue(3'd1, 32'h0010_0000, 32'hCAFE_F00D, 0, 1, "R8");
    issue(3'd4, 32'h0BAD_0BAD, 32'hFFFF_0000, 1, 0, "R8");
    issue(3'd0, 32'h1111_1111, 32'h2222_2222, 1, 1, "R8");
    issue(3'd1, 32'hFFFF_FFFF, 32'h0000_8001, 1, 0, "R8");
    issue(3'd0, 32'h0000_8000, 32'h0, 0, 1, "R8");
    idle(1);
    issue(3'd0, 32'h4000_0000, 32'h4000_0000, 0, 0, "R3");
    issue(3'd1, 32'h0, 32'h9999_9999, 0, 1, "R8");
    idle(6);
    check(q.size() == 0, "R2", "results outstanding", q.size(), 32'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule